// File: doc/BRIEF.md
# Serial-access discrete input sense register slave

This block is the digital half of a 32-channel discrete threshold sensor. Channel levels arrive from comparators outside the block as a digital vector. They are sampled every clock into a sense register. A host reads that register, and a small set of configuration registers, over a mode-0 SPI link. The configuration covers a control byte, per-bank sensing-mode bits, a test byte and two 16-bit threshold words. The sensing-mode bits and the thresholds are driven out to the comparator side.

SPI pins are oversampled by the system clock. A rising SCK edge found this way advances a frame state machine with four states. IDLE means chip select is inactive. CMD collects the first byte. RD shifts register data out. WR takes in data bytes. The transitions are:
- IDLE to CMD when chip select goes active.
- CMD to RD or to WR on the eighth rising edge, as the top command bit selects.
- Any state to IDLE when chip select goes inactive.

A threshold write whose hysteresis is odd puts the block in a locked state. In that state the sense register stops following the inputs. Only a hardware reset or a software reset clears the lock.

Top module: `discrete_sense_spi`

## Requirements
- R1: The command byte arrives MSB first and is sampled on rising SCK. Bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 hold the register address. Read data moves to the next bit only after a rising edge, so the host samples each bit on the rising edge.
- R2: The byte registers read back what was written and reset to 0x00. These are the control register at 0x02 (bit 0 test flag, bit 1 software reset), the sensing-mode register at 0x04 and the test byte at 0x1E.
- R3: The threshold words at 0x3A (ground-open) and 0x3C (supply-open) reset to 0x0206, with hysteresis in bits 15:8 and center in bits 7:0. A read returns the high byte first. A write takes the high byte and then the low byte, and commits on the second byte. Both words are driven on thr_gnd and thr_sup.
- R4: The sense byte registers hold channels 7:0 at 0x10, 15:8 at 0x12, 23:16 at 0x14 and 31:24 at 0x16. Address 0x78 returns all 32 channels in four bytes, bits 31:24 first.
- R5: Bit n of the sensing-mode register selects supply-open (1) or ground-open (0) sensing for channels 8n to 8n+7. These bits drive bank_sel.
- R6: A threshold write with bit 8 set (odd hysteresis) raises locked, and the sense register then holds its value. An even-hysteresis write does not clear the lock.
- R7: Writing control bit 1 = 1 clears the lock and returns every other register to its reset value. While that bit stays 1, writes to registers other than control are ignored. Writing it back to 0 releases the block.
- R8: Chip select going inactive aborts a partial byte, and the next frame starts with a fresh command byte.
- R9: Reading an unmapped address returns 0x00, and writing one changes nothing. Clocks beyond a register's length shift out 0x00.
- R10: In a write frame, bytes beyond the register's length are ignored. A byte register keeps the first data byte.
- R11: While unlocked, the sense register takes the channel inputs on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sck | input | 1 | SPI clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| sense_in | input | 32 | Digital channel levels from the comparators |
| bank_sel | output | 4 | Per-bank sensing mode, 1 = supply-open |
| thr_gnd | output | 16 | Ground-open threshold word |
| thr_sup | output | 16 | Supply-open threshold word |
| locked | output | 1 | Odd-hysteresis lock state |

## Verification
The bench builds the block with its defaults: four banks of eight channels. This gives a full 32-bit sense word, so every sense byte address and the four-byte word read are reachable. All four sensing-mode bits are also present. The scoreboard compares each byte shifted out against values derived from the register map. This covers the most-significant-first order of the words, zero fill beyond a register's length and the value frozen under lock. Port checks cover locked, bank_sel and the threshold outputs.

// File: rtl/dsense_pkg.sv
package dsense_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_RD,
        ST_WR
    } frame_st_e;

    localparam logic [6:0]  A_CTRL     = 7'h02;
    localparam logic [6:0]  A_MODE     = 7'h04;
    localparam logic [6:0]  A_TEST     = 7'h1E;
    localparam logic [6:0]  A_THR_GND  = 7'h3A;
    localparam logic [6:0]  A_THR_SUP  = 7'h3C;
    localparam logic [6:0]  A_SENSE_B0 = 7'h10;
    localparam logic [6:0]  A_SENSE_W  = 7'h78;
    localparam logic [15:0] THR_RST    = 16'h0206;

    // number of data bytes a register carries
    function automatic logic [2:0] reg_len(input logic [6:0] a);
        if (a == A_THR_GND || a == A_THR_SUP) return 3'd2;
        if (a == A_SENSE_W)                   return 3'd4;
        return 3'd1;
    endfunction

endpackage

// File: rtl/dsense_sync.sv
module dsense_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic cs_act,
    output logic mosi_s
);
    logic sck_a, sck_b, cs_a, mosi_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_a  <= 1'b0;
            sck_b  <= 1'b0;
            cs_a   <= 1'b1;
            mosi_a <= 1'b0;
        end else begin
            sck_a  <= sck;
            sck_b  <= sck_a;
            cs_a   <= cs_n;
            mosi_a <= mosi;
        end
    end

    assign sck_rise = sck_a & ~sck_b;
    assign cs_act   = ~cs_a;
    assign mosi_s   = mosi_a;
endmodule

// File: rtl/dsense_frame.sv
module dsense_frame
    import dsense_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_rise,
    input  logic        cs_act,
    input  logic        mosi_s,
    input  logic [31:0] rd_word,
    output logic [6:0]  rd_addr,
    output logic        wr_en,
    output logic [6:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        miso,
    output frame_st_e   state
);
    frame_st_e   state_q, state_d;
    logic [2:0]  bit_q;
    logic [6:0]  sh_q;
    logic [6:0]  addr_q;
    logic [1:0]  nbyte_q;
    logic [7:0]  hi_q;
    logic [31:0] tx_q;
    logic [7:0]  sh_next;
    logic        byte_done;
    logic [2:0]  wlen;

    assign sh_next   = {sh_q, mosi_s};
    assign byte_done = sck_rise && (bit_q == 3'd7);
    assign wlen      = reg_len(addr_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_act) state_d = ST_CMD;
            ST_CMD: begin
                if (!cs_act)        state_d = ST_IDLE;
                else if (byte_done) state_d = sh_next[7] ? ST_RD : ST_WR;
            end
            ST_RD:   if (!cs_act) state_d = ST_IDLE;
            ST_WR:   if (!cs_act) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, count and capture datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            sh_q    <= '0;
            addr_q  <= '0;
            nbyte_q <= '0;
            hi_q    <= '0;
            tx_q    <= '0;
        end else if (!cs_act) begin
            bit_q   <= '0;
            nbyte_q <= '0;
        end else if (sck_rise) begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= sh_next[6:0];
            if (state_q == ST_CMD && byte_done) begin
                addr_q <= sh_next[6:0];
                tx_q   <= sh_next[7] ? rd_word : '0;
            end
            if (state_q == ST_RD)
                tx_q <= {tx_q[30:0], 1'b0};
            if (state_q == ST_WR && byte_done) begin
                if (nbyte_q == 2'd0) hi_q <= sh_next;
                if (nbyte_q != 2'd3) nbyte_q <= nbyte_q + 2'd1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr = (state_q == ST_CMD) ? sh_next[6:0] : addr_q;
        wr_addr = addr_q;
        wr_en   = (state_q == ST_WR) && byte_done &&
                  ((wlen == 3'd1 && nbyte_q == 2'd0) ||
                   (wlen == 3'd2 && nbyte_q == 2'd1));
        wr_data = (wlen == 3'd2) ? {hi_q, sh_next} : {8'h00, sh_next};
        miso    = (state_q == ST_RD) & tx_q[31];
        state   = state_q;
    end
endmodule

// File: rtl/dsense_regs.sv
module dsense_regs
    import dsense_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int BANK_W  = 8,
    localparam int CH     = N_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [6:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [6:0]        rd_addr,
    input  logic [CH-1:0]     sense_in,
    output logic [31:0]       rd_word,
    output logic [N_BANKS-1:0] bank_sel,
    output logic [15:0]       thr_gnd,
    output logic [15:0]       thr_sup,
    output logic              locked,
    output logic              srst,
    output logic [CH-1:0]     sense_q
);
    logic [1:0]         ctrl_q;
    logic [N_BANKS-1:0] mode_q;
    logic [7:0]         test_q;
    logic [15:0]        thr_g_q, thr_s_q;
    logic               lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            test_q  <= '0;
            thr_g_q <= THR_RST;
            thr_s_q <= THR_RST;
            lock_q  <= 1'b0;
            sense_q <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[1:0];
            if (ctrl_q[1]) begin
                mode_q  <= '0;
                test_q  <= '0;
                thr_g_q <= THR_RST;
                thr_s_q <= THR_RST;
                lock_q  <= 1'b0;
            end else if (wr_en) begin
                case (wr_addr)
                    A_MODE: mode_q <= wr_data[N_BANKS-1:0];
                    A_TEST: test_q <= wr_data[7:0];
                    A_THR_GND: begin
                        thr_g_q <= wr_data;
                        if (wr_data[8]) lock_q <= 1'b1;
                    end
                    A_THR_SUP: begin
                        thr_s_q <= wr_data;
                        if (wr_data[8]) lock_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!lock_q) sense_q <= sense_in;
        end
    end

    // read mux, left-aligned to the register length
    always_comb begin
        logic [31:0] v;
        logic [2:0]  len;
        v   = '0;
        len = reg_len(rd_addr);
        case (rd_addr)
            A_CTRL:    v = 32'(ctrl_q);
            A_MODE:    v = 32'(mode_q);
            A_TEST:    v = 32'(test_q);
            A_THR_GND: v = 32'(thr_g_q);
            A_THR_SUP: v = 32'(thr_s_q);
            A_SENSE_W: v = 32'(sense_q);
            default:   v = '0;
        endcase
        for (int b = 0; b < N_BANKS; b++)
            if (rd_addr == 7'(A_SENSE_B0 + 2 * b))
                v = 32'(sense_q[b*BANK_W +: BANK_W]);
        rd_word = v << (6'd32 - {len, 3'b000});
    end

    assign bank_sel = mode_q;
    assign thr_gnd  = thr_g_q;
    assign thr_sup  = thr_s_q;
    assign locked   = lock_q;
    assign srst     = ctrl_q[1];
endmodule

// File: rtl/discrete_sense_spi.sv
module discrete_sense_spi
    import dsense_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int BANK_W  = 8,
    localparam int CH     = N_BANKS * BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               miso,
    input  logic [CH-1:0]      sense_in,
    output logic [N_BANKS-1:0] bank_sel,
    output logic [15:0]        thr_gnd,
    output logic [15:0]        thr_sup,
    output logic               locked
);
    logic        sck_rise, cs_act, mosi_s;
    logic [31:0] rd_word;
    logic [6:0]  rd_addr, wr_addr;
    logic        wr_en, srst;
    logic [15:0] wr_data;
    logic [CH-1:0] sense_q;
    frame_st_e   state;

    dsense_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    dsense_frame u_frame (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_act(cs_act),
        .mosi_s(mosi_s), .rd_word(rd_word), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(miso), .state(state)
    );

    dsense_regs #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .sense_in(sense_in),
        .rd_word(rd_word), .bank_sel(bank_sel), .thr_gnd(thr_gnd),
        .thr_sup(thr_sup), .locked(locked), .srst(srst), .sense_q(sense_q)
    );
endmodule

// File: rtl/dsense_chk.sv
module dsense_chk
    import dsense_pkg::*;
#(
    parameter int CH = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_act,
    input frame_st_e     state,
    input logic          miso,
    input logic          locked,
    input logic          srst,
    input logic [CH-1:0] sense_in,
    input logic [CH-1:0] sense_q
);
    a_r8_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> state == ST_IDLE);

    a_r9_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && $past(!cs_act)) |-> !miso);

    a_r6_sense_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sense_q));

    a_r11_sense_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> sense_q == $past(sense_in));

    a_r7_srst_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !locked);
endmodule

bind discrete_sense_spi dsense_chk #(.CH(CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .state(state), .miso(miso),
    .locked(locked), .srst(srst), .sense_in(sense_in), .sense_q(sense_q)
);

// File: tb/discrete_sense_spi_test.sv
`timescale 1ns/1ps
module discrete_sense_spi_test;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [31:0] sense_in = '0;
    logic miso, locked;
    logic [3:0] bank_sel;
    logic [15:0] thr_gnd, thr_sup;

    int n_tests = 0, n_fail = 0;

    typedef struct { logic [7:0] v; int r; } exp_t;
    exp_t exp_q[$];
    logic [7:0] got_b;
    event got_ev;

    always #2.5 clk = ~clk;

    discrete_sense_spi uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .sense_in(sense_in), .bank_sel(bank_sel),
        .thr_gnd(thr_gnd), .thr_sup(thr_sup), .locked(locked)
    );

    task automatic chk(input bit ok, input int r, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
        end
    endtask

    // monitor: pops the scoreboard each time a byte is shifted out
    initial forever begin
        exp_t e;
        @(got_ev);
        if (exp_q.size() == 0) chk(1'b0, 0, {24'h0, got_b}, 32'h0);
        else begin
            e = exp_q.pop_front();
            chk(got_b === e.v, e.r, {24'h0, got_b}, {24'h0, e.v});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            wait_clk(HALF);
            i[b] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_on;
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_off;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic wr(input logic [6:0] a, input int n, input logic [31:0] d);
        logic [7:0] dummy;
        cs_on();
        spi_byte({1'b0, a}, dummy);
        for (int k = n - 1; k >= 0; k--) spi_byte(d[8*k +: 8], dummy);
        cs_off();
    endtask

    // driver: pushes expected bytes, then runs the read frame
    task automatic rd(input logic [6:0] a, input int n, input logic [31:0] e, input int r);
        logic [7:0] x;
        for (int k = n - 1; k >= 0; k--) exp_q.push_back('{v: e[8*k +: 8], r: r});
        cs_on();
        spi_byte({1'b1, a}, x);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'h00, x);
            got_b = x;
            ->got_ev;
        end
        cs_off();
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // reset state: R3 thresholds, R5 modes, R6 lock
        chk(locked === 1'b0, 6, {31'h0, locked}, 0);
        chk(bank_sel === 4'h0, 5, {28'h0, bank_sel}, 0);
        chk(thr_gnd === 16'h0206, 3, {16'h0, thr_gnd}, 32'h0206);
        chk(thr_sup === 16'h0206, 3, {16'h0, thr_sup}, 32'h0206);
        chk(miso === 1'b0, 9, {31'h0, miso}, 0);

        sense_in = 32'hA1B2C3D4;
        wait_clk(4);
        rd(7'h78, 4, 32'hA1B2C3D4, 4);           // R4 word, high byte first
        rd(7'h10, 1, 32'hD4, 4);                 // R4
        rd(7'h12, 1, 32'hC3, 4);                 // R4
        rd(7'h16, 1, 32'hA1, 4);                 // R4
        rd(7'h3A, 2, 32'h0206, 3);               // R3
        rd(7'h02, 1, 32'h00, 2);                 // R2
        rd(7'h04, 1, 32'h00, 2);                 // R2
        rd(7'h1E, 1, 32'h00, 2);                 // R2

        wr(7'h1E, 1, 32'h5A);                    // R1 write flag clear
        rd(7'h1E, 1, 32'h5A, 1);                 // R1 read flag set
        wr(7'h02, 1, 32'h01);
        rd(7'h02, 1, 32'h01, 2);                 // R2 test flag

        wr(7'h04, 2, 32'h030F);                  // R10 extra byte ignored
        rd(7'h04, 1, 32'h03, 10);
        chk(bank_sel === 4'h3, 5, {28'h0, bank_sel}, 3);   // R5

        wr(7'h3C, 2, 32'h040A);                  // R3 high then low
        rd(7'h3C, 2, 32'h040A, 3);
        chk(thr_sup === 16'h040A, 3, {16'h0, thr_sup}, 32'h040A);

        // R8 abort: five bits then deselect
        cs_on();
        for (int b = 0; b < 5; b++) begin
            mosi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        cs_off();
        rd(7'h04, 1, 32'h03, 8);
        wr(7'h04, 1, 32'h0C);
        rd(7'h04, 1, 32'h0C, 8);

        rd(7'h20, 1, 32'h00, 9);                 // R9 unmapped read
        wr(7'h05, 1, 32'hFF);                    // R9 unmapped write
        rd(7'h04, 1, 32'h0C, 9);
        rd(7'h02, 3, 32'h010000, 9);             // R9 zero fill

        wr(7'h3A, 2, 32'h0306);                  // R6 odd hysteresis
        chk(locked === 1'b1, 6, {31'h0, locked}, 1);
        sense_in = 32'h11223344;
        wait_clk(4);
        rd(7'h78, 4, 32'hA1B2C3D4, 6);           // R6 frozen
        wr(7'h3A, 2, 32'h0206);
        chk(locked === 1'b1, 6, {31'h0, locked}, 1);

        wr(7'h02, 1, 32'h02);                    // R7 software reset
        chk(locked === 1'b0, 7, {31'h0, locked}, 0);
        wr(7'h04, 1, 32'h0F);
        rd(7'h04, 1, 32'h00, 7);
        rd(7'h02, 1, 32'h02, 7);
        wr(7'h02, 1, 32'h00);
        rd(7'h3A, 2, 32'h0206, 7);
        rd(7'h3C, 2, 32'h0206, 7);
        rd(7'h1E, 1, 32'h00, 7);
        rd(7'h02, 1, 32'h00, 7);
        chk(bank_sel === 4'h0, 7, {28'h0, bank_sel}, 0);

        rd(7'h78, 4, 32'h11223344, 11);          // R11 tracking again
        sense_in = 32'hDEADBEEF;
        wait_clk(4);
        rd(7'h10, 1, 32'hEF, 11);
        rd(7'h14, 1, 32'hAD, 11);

        wait_clk(10);
        chk(exp_q.size() == 0, 9, exp_q.size(), 0);
        report();
    end
endmodule